// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind a small byte-wide register bus. Software programs each channel by writing a control word to the command address. The control word picks how the count bytes are moved, which counting mode is used, and whether counting is binary or four-digit BCD. The initial count is then written one or two bytes at a time to the channel's own address. Counts move only on cycles where the shared `tick_i` enable is high, so a fixed slow timebase can drive the block from a fast core clock.

Software reads a running count in one of two ways. It can read the live value, or it can first freeze a copy with a latch command. A read-back command snapshots the counts, the status, or both, for any subset of the channels in one write. The status byte shows the configured control bits, whether a new count is still awaited, and the present output level. Each channel has a gate input that can pause counting and an output whose waveform depends on the mode.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset the channels hold control bits 0x36, 0x34 and 0x36 (channels 0, 1, 2; the low six bits of 0x36, 0x74, 0xB6). Every output is high, every channel awaits a count, and every live count reads 0.
- R2: A write to address 3 with bits 7:6 = channel number and bits 5:4 non-zero does several things. It stores bits 5:0 as that channel's control, clears its count to 0 and marks it as awaiting a count. It also resets both byte toggles and drops any held count or status latch.
- R3: Writes to a channel address load its count according to access bits 5:4. A value of 1 writes only the low byte and 2 writes only the high byte; either completes the load at once, and the byte not written stays 0. A value of 3 takes the low byte first and then the high byte. The live counter takes the new count only when the load completes, and until then it neither changes nor counts.
- R4: Reads use a toggle of their own, separate from the write toggle. With access 3 the reads return low then high, and with access 1 or 2 every read returns the same byte. Reading address 3 returns 0xFF and has no effect.
- R5: A control word with bits 5:4 = 0 freezes the selected channel's current count. Later latch requests are ignored while a frozen value is held. The freeze ends once the final byte of it has been read.
- R6: A control word with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes their counts and bit 4 = 0 freezes their status. When both are held, the status is read first and then the count.
- R7: The status byte is {output level, awaiting-count flag, control bits 5:0}. It is returned by exactly one read and then discarded; while one is held, further status requests are ignored.
- R8: Each enabled tick decrements the count. In binary mode 0 wraps to 0xFFFF. In BCD mode (bit 0 = 1) the digits borrow in decimal and 0 wraps to 0x9999.
- R9: In modes 2 and 3 a tick at count 1 reloads the programmed count. Other modes wrap through the full range. A programmed count of 0 behaves as the maximum count. Mode codes 6 and 7 act as 2 and 3.
- R10: With the gate low, counting halts in modes 0, 2, 3 and 4. Modes 1 and 5 count regardless of the gate.
- R11: In modes 0 and 1 the output goes low on programming and goes high when the count reaches 0, then stays high. In mode 2 it is low for the one tick period after each reload. In mode 3 it toggles at each reload. In modes 4 and 5 it is low for the one tick period after the count first reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counting enable, one pulse per timebase period |
| addr_i | input | 2 | Register select: 0 to 2 channel count, 3 control |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during the cycle rd_i is high |
| gate_i | input | 3 | Per-channel gate |
| out_o | output | 3 | Per-channel output |

## Verification
The bench targets the interplay of the byte toggles with the latches. It reads between the two halves of a count load to show that the read toggle runs on its own, and that the live count stays at 0 until the high byte arrives. A design that shared one toggle, or that loaded the count early, would return the wrong byte or a partial count. It repeats latch commands between the two bytes of a frozen count, so a design that relatched early shows the newer count. It issues a combined read-back and checks that the status comes out ahead of the frozen count; it also reprograms a channel partway through a read to show that the stale latch and toggle are gone. The BCD wrap to 9999, the decimal borrow from 0x0100, the reload at count 1, the effect of the gate per mode, and the output edges of modes 0, 2, 3 and 4 are each checked at the exact tick where a wrong design would diverge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned DIGITS = 4;
  localparam int unsigned CNT_W  = 4 * DIGITS;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_t;

  function automatic ctrl_t reset_ctrl(input int unsigned ch);
    ctrl_t c;
    c.acc  = ACC_LOHI;
    c.bcd  = 1'b0;
    c.mode = (ch == 1) ? 3'd2 : 3'd3;
    return c;
  endfunction

  // codes 6/7 alias to 2/3
  function automatic logic [2:0] eff_mode(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction

  // output level right after programming
  function automatic logic idle_level(input logic [2:0] m);
    logic [2:0] e;
    e = eff_mode(m);
    return !(e == 3'd0 || e == 3'd1);
  endfunction
endpackage

// File: rtl/tmr_dec.sv
`timescale 1ns/1ps
module tmr_dec #(
  parameter int unsigned DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val_i,
  input  logic                bcd_i,
  output logic [4*DIGITS-1:0] dec_o
);
  localparam int unsigned W = 4 * DIGITS;

  logic [DIGITS-1:0] borrow;
  logic [W-1:0]      bcd_res;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] dig;
    assign dig = val_i[4*g +: 4];
    assign bcd_res[4*g +: 4] = !borrow[g] ? dig : ((dig == 4'd0) ? 4'd9 : dig - 4'd1);
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] && (dig == 4'd0);
    end
  end

  assign dec_o = bcd_i ? bcd_res : val_i - W'(1);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CH = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              ctrl_wr_i,
  input  ctrl_t             ctrl_i,
  input  logic              cnt_latch_i,
  input  logic              stat_latch_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  count_q, cnt_q, latch_q;
  logic              pend_q, wtog_q, rtog_q, latch_vld_q, stat_vld_q, out_q, done_q;
  logic [BYTE_W-1:0] stat_q;

  logic [2:0]        mode;
  logic              gate_free, run, at_one, reload;
  logic [CNT_W-1:0]  cnt_dec, cnt_nxt, new_count, rd_src;
  logic              wr_done, wtog_nxt, rd_final, rtog_nxt;
  logic [BYTE_W-1:0] status_now;

  assign mode      = eff_mode(ctrl_q.mode);
  assign gate_free = (mode == 3'd1) || (mode == 3'd5);
  assign run       = !pend_q && tick_i && (gate_i || gate_free);
  assign at_one    = (cnt_q == CNT_W'(1));
  assign reload    = run && at_one && (mode == 3'd2 || mode == 3'd3);

  tmr_dec #(.DIGITS(DIGITS)) u_dec (
    .val_i(cnt_q),
    .bcd_i(ctrl_q.bcd),
    .dec_o(cnt_dec)
  );

  assign cnt_nxt    = reload ? count_q : cnt_dec;
  assign status_now = {out_q, pend_q, ctrl_q};
  assign rd_src     = latch_vld_q ? latch_q : cnt_q;

  // count write path
  always_comb begin
    new_count = count_q;
    wr_done   = 1'b0;
    wtog_nxt  = wtog_q;
    unique case (ctrl_q.acc)
      ACC_LO: begin
        new_count = {count_q[CNT_W-1:BYTE_W], wdata_i};
        wr_done   = 1'b1;
      end
      ACC_HI: begin
        new_count = {wdata_i, count_q[BYTE_W-1:0]};
        wr_done   = 1'b1;
      end
      ACC_LOHI: begin
        if (!wtog_q) begin
          new_count = {count_q[CNT_W-1:BYTE_W], wdata_i};
          wtog_nxt  = 1'b1;
        end else begin
          new_count = {wdata_i, count_q[BYTE_W-1:0]};
          wtog_nxt  = 1'b0;
          wr_done   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // read path
  always_comb begin
    rdata_o  = '0;
    rd_final = 1'b0;
    rtog_nxt = rtog_q;
    if (stat_vld_q) begin
      rdata_o = stat_q;
    end else begin
      unique case (ctrl_q.acc)
        ACC_LO: begin
          rdata_o  = rd_src[BYTE_W-1:0];
          rd_final = 1'b1;
        end
        ACC_HI: begin
          rdata_o  = rd_src[CNT_W-1:BYTE_W];
          rd_final = 1'b1;
        end
        ACC_LOHI: begin
          if (!rtog_q) begin
            rdata_o  = rd_src[BYTE_W-1:0];
            rtog_nxt = 1'b1;
          end else begin
            rdata_o  = rd_src[CNT_W-1:BYTE_W];
            rtog_nxt = 1'b0;
            rd_final = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= reset_ctrl(CH);
      count_q     <= '0;
      cnt_q       <= '0;
      latch_q     <= '0;
      stat_q      <= '0;
      pend_q      <= 1'b1;
      wtog_q      <= 1'b0;
      rtog_q      <= 1'b0;
      latch_vld_q <= 1'b0;
      stat_vld_q  <= 1'b0;
      out_q       <= idle_level(reset_ctrl(CH).mode);
      done_q      <= 1'b0;
    end else if (ctrl_wr_i) begin
      ctrl_q      <= ctrl_i;
      count_q     <= '0;
      cnt_q       <= '0;
      pend_q      <= 1'b1;
      wtog_q      <= 1'b0;
      rtog_q      <= 1'b0;
      latch_vld_q <= 1'b0;
      stat_vld_q  <= 1'b0;
      out_q       <= idle_level(ctrl_i.mode);
      done_q      <= 1'b0;
    end else begin
      if (data_wr_i) begin
        count_q <= new_count;
        wtog_q  <= wtog_nxt;
        pend_q  <= 1'b1;
        if (wr_done) begin
          cnt_q  <= new_count;
          pend_q <= 1'b0;
          out_q  <= idle_level(ctrl_q.mode);
          done_q <= 1'b0;
        end
      end else if (run) begin
        cnt_q <= cnt_nxt;
        unique case (mode)
          3'd0, 3'd1: if (at_one) out_q <= 1'b1;
          3'd2:       out_q <= !at_one;
          3'd3:       if (at_one) out_q <= !out_q;
          default: begin
            if (at_one && !done_q) begin
              out_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              out_q  <= 1'b1;
            end
          end
        endcase
      end

      if (cnt_latch_i && !latch_vld_q) begin
        latch_q     <= cnt_q;
        latch_vld_q <= 1'b1;
      end else if (data_rd_i && !stat_vld_q && rd_final) begin
        latch_vld_q <= 1'b0;
      end

      if (stat_latch_i && !stat_vld_q) begin
        stat_q     <= status_now;
        stat_vld_q <= 1'b1;
      end else if (data_rd_i && stat_vld_q) begin
        stat_vld_q <= 1'b0;
      end

      if (data_rd_i && !stat_vld_q) rtog_q <= rtog_nxt;
    end
  end

  assign out_o = out_q;

  AST_PEND_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !data_wr_i && !ctrl_wr_i |=> $stable(cnt_q)); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_vld_q && !ctrl_wr_i && !data_rd_i |=> latch_vld_q && $stable(latch_q)); // R5
  AST_STAT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_vld_q && data_rd_i |=> !stat_vld_q); // R7
  AST_GATE_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i && !gate_free && !ctrl_wr_i && !data_wr_i |=> $stable(cnt_q)); // R10
  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 3'd0 || mode == 3'd1) && out_q && !ctrl_wr_i && !data_wr_i |=> out_q); // R11
endmodule

// File: rtl/tri_interval_timer.sv
`timescale 1ns/1ps
module tri_interval_timer
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] gate_i,
  output logic [NUM_CH-1:0] out_o
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_CH);
  localparam logic [1:0]        RB_SEL   = 2'd3;

  logic              cmd_wr, is_rb;
  logic [1:0]        sel;
  ctrl_t             cw;
  logic [NUM_CH-1:0] ctrl_wr, cnt_latch, stat_latch, data_wr, data_rd;
  logic [BYTE_W-1:0] ch_rdata [NUM_CH];

  assign cmd_wr = wr_i && (addr_i == CMD_ADDR);
  assign sel    = wdata_i[7:6];
  assign is_rb  = (sel == RB_SEL);
  assign cw     = ctrl_t'(wdata_i[5:0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit           = !is_rb && (sel == 2'(g));
    assign ctrl_wr[g]    = cmd_wr && hit && (cw.acc != ACC_LATCH);
    assign cnt_latch[g]  = cmd_wr && ((hit && cw.acc == ACC_LATCH) ||
                                      (is_rb && !wdata_i[5] && wdata_i[1+g]));
    assign stat_latch[g] = cmd_wr && is_rb && !wdata_i[4] && wdata_i[1+g];
    assign data_wr[g]    = wr_i && (addr_i == ADDR_W'(g));
    assign data_rd[g]    = rd_i && (addr_i == ADDR_W'(g));

    tmr_channel #(.CH(g)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .gate_i      (gate_i[g]),
      .ctrl_wr_i   (ctrl_wr[g]),
      .ctrl_i      (cw),
      .cnt_latch_i (cnt_latch[g]),
      .stat_latch_i(stat_latch[g]),
      .data_wr_i   (data_wr[g]),
      .data_rd_i   (data_rd[g]),
      .wdata_i     (wdata_i),
      .rdata_o     (ch_rdata[g]),
      .out_o       (out_o[g])
    );
  end

  always_comb begin
    rdata_o = '1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = ch_rdata[i];
    end
  end

  AST_ONE_CTRL_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_wr | data_wr)); // R2
  AST_CMD_READ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == CMD_ADDR && !wr_i && !tick_i |=> $stable(out_o)); // R4
endmodule

// File: tb/tri_interval_timer_bench.sv
`timescale 1ns/1ps
module tri_interval_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] gate_i = 3'b111;
  logic [2:0] out_o;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2 clk_i = ~clk_i;

  tri_interval_timer u_tri_interval_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .gate_i(gate_i), .out_o(out_o)
  );

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk(req, v, exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 outputs", {5'd0, out_o}, 8'h07);
    bus_wr(3, 8'hEE);
    rd_chk("R1 status ch0", 0, 8'hF6);
    rd_chk("R1 status ch1", 1, 8'hF4);
    rd_chk("R1 status ch2", 2, 8'hF6);
    rd_chk("R1 count lo", 0, 8'h00);
    rd_chk("R1 count hi", 0, 8'h00);
    rd_chk("R4 cmd addr read", 3, 8'hFF);
  endtask

  task automatic t_latch_reload();
    bus_wr(3, 8'h34); bus_wr(0, 8'h05); bus_wr(0, 8'h00);
    ticks(1);
    bus_wr(3, 8'h00);
    ticks(2);
    rd_chk("R5 frozen lo", 0, 8'h04);
    bus_wr(3, 8'h00);
    rd_chk("R5 frozen hi", 0, 8'h00);
    bus_wr(3, 8'h00);
    rd_chk("R5 relatch lo", 0, 8'h02);
    rd_chk("R5 relatch hi", 0, 8'h00);
    ticks(1);
    chk("R11 mode2 high", {7'd0, out_o[0]}, 8'h01);
    ticks(1);
    chk("R11 mode2 pulse", {7'd0, out_o[0]}, 8'h00);
    rd_chk("R9 reload lo", 0, 8'h05);
    rd_chk("R9 reload hi", 0, 8'h00);
    ticks(1);
    chk("R11 mode2 back", {7'd0, out_o[0]}, 8'h01);
  endtask

  task automatic t_reprogram();
    bus_wr(3, 8'h34); bus_wr(0, 8'h05); bus_wr(0, 8'h00);
    bus_wr(3, 8'h00);
    rd_chk("R2 pre lo", 0, 8'h05);
    bus_wr(3, 8'h34); bus_wr(0, 8'h07); bus_wr(0, 8'h00);
    rd_chk("R2 toggle reset lo", 0, 8'h07);
    rd_chk("R2 toggle reset hi", 0, 8'h00);
  endtask

  task automatic t_pending();
    bus_wr(3, 8'h34); bus_wr(0, 8'h10);
    bus_wr(3, 8'hE2);
    rd_chk("R7 status pending", 0, 8'hF4);
    rd_chk("R3 not yet loaded lo", 0, 8'h00);
    rd_chk("R4 own toggle hi", 0, 8'h00);
    bus_wr(0, 8'h00);
    rd_chk("R3 loaded lo", 0, 8'h10);
    rd_chk("R3 loaded hi", 0, 8'h00);
    bus_wr(3, 8'hE2);
    rd_chk("R7 status done", 0, 8'hB4);
    rd_chk("R7 status consumed", 0, 8'h10);
    rd_chk("R7 then hi", 0, 8'h00);
  endtask

  task automatic t_bcd_and_mode0();
    bus_wr(3, 8'h71); bus_wr(1, 8'h00); bus_wr(1, 8'h00);
    ticks(1);
    rd_chk("R8 bcd wrap lo", 1, 8'h99);
    rd_chk("R9 zero max hi", 1, 8'h99);
    bus_wr(3, 8'h71); bus_wr(1, 8'h00); bus_wr(1, 8'h01);
    ticks(1);
    rd_chk("R8 bcd borrow lo", 1, 8'h99);
    rd_chk("R8 bcd borrow hi", 1, 8'h00);
    bus_wr(3, 8'h70); bus_wr(1, 8'h00); bus_wr(1, 8'h00);
    ticks(1);
    rd_chk("R8 bin wrap lo", 1, 8'hFF);
    rd_chk("R8 bin wrap hi", 1, 8'hFF);
    bus_wr(3, 8'h70);
    chk("R11 mode0 low", {7'd0, out_o[1]}, 8'h00);
    bus_wr(1, 8'h02); bus_wr(1, 8'h00);
    ticks(1);
    chk("R11 mode0 still low", {7'd0, out_o[1]}, 8'h00);
    ticks(1);
    chk("R11 mode0 terminal", {7'd0, out_o[1]}, 8'h01);
    ticks(1);
    chk("R11 mode0 held", {7'd0, out_o[1]}, 8'h01);
  endtask

  task automatic t_access();
    bus_wr(3, 8'h96); bus_wr(2, 8'h34);
    rd_chk("R4 lo only", 2, 8'h34);
    rd_chk("R4 lo only again", 2, 8'h34);
    bus_wr(3, 8'hA6); bus_wr(2, 8'h12);
    rd_chk("R3 hi only", 2, 8'h12);
    ticks(1);
    rd_chk("R3 low byte zero", 2, 8'h11);
  endtask

  task automatic t_gate();
    bus_wr(3, 8'hB6); bus_wr(2, 8'h08); bus_wr(2, 8'h00);
    gate_i[2] = 1'b0;
    ticks(3);
    rd_chk("R10 paused lo", 2, 8'h08);
    rd_chk("R10 paused hi", 2, 8'h00);
    gate_i[2] = 1'b1;
    ticks(1);
    rd_chk("R10 resumed", 2, 8'h07);
    rd_chk("R10 resumed hi", 2, 8'h00);
    bus_wr(3, 8'hB2); bus_wr(2, 8'h08); bus_wr(2, 8'h00);
    gate_i[2] = 1'b0;
    ticks(1);
    rd_chk("R10 mode1 ignores gate", 2, 8'h07);
    rd_chk("R10 mode1 hi", 2, 8'h00);
    gate_i[2] = 1'b1;
  endtask

  task automatic t_readback();
    bus_wr(3, 8'h34); bus_wr(0, 8'h20); bus_wr(0, 8'h00);
    bus_wr(3, 8'hB4); bus_wr(2, 8'h30); bus_wr(2, 8'h00);
    ticks(1);
    bus_wr(3, 8'hCA);
    ticks(2);
    rd_chk("R6 ch0 status first", 0, 8'hB4);
    rd_chk("R6 ch0 frozen lo", 0, 8'h1F);
    rd_chk("R6 ch0 frozen hi", 0, 8'h00);
    rd_chk("R6 ch0 live lo", 0, 8'h1D);
    rd_chk("R6 ch0 live hi", 0, 8'h00);
    rd_chk("R6 ch2 status", 2, 8'hB4);
    rd_chk("R6 ch2 frozen lo", 2, 8'h2F);
    rd_chk("R6 ch2 frozen hi", 2, 8'h00);
  endtask

  task automatic t_modes_345();
    bus_wr(3, 8'h36); bus_wr(0, 8'h02); bus_wr(0, 8'h00);
    ticks(1);
    chk("R11 mode3 high", {7'd0, out_o[0]}, 8'h01);
    ticks(1);
    chk("R11 mode3 toggle low", {7'd0, out_o[0]}, 8'h00);
    ticks(2);
    chk("R11 mode3 toggle high", {7'd0, out_o[0]}, 8'h01);
    bus_wr(3, 8'h38); bus_wr(0, 8'h02); bus_wr(0, 8'h00);
    ticks(1);
    chk("R11 mode4 before", {7'd0, out_o[0]}, 8'h01);
    ticks(1);
    chk("R11 mode4 strobe", {7'd0, out_o[0]}, 8'h00);
    ticks(1);
    chk("R11 mode4 after", {7'd0, out_o[0]}, 8'h01);
    bus_wr(3, 8'h3C); bus_wr(0, 8'h03); bus_wr(0, 8'h00);
    ticks(3);
    rd_chk("R9 mode6 alias reload", 0, 8'h03);
    rd_chk("R9 mode6 alias hi", 0, 8'h00);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_latch_reload();
    t_reprogram();
    t_pending();
    t_bcd_and_mode0();
    t_access();
    t_gate();
    t_readback();
    t_modes_345();
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule